// File: doc/BRIEF.md
# Dirty Rectangle Redraw Queue

This block gathers screen regions that a display pipeline has to repaint. Each region arrives as a signed origin and extent (x, y, w, h) and goes into a power-of-two ring of entries. When the display side asks for a flush, the queue drains its entries oldest first and presents one region per accepted handshake on an update port.

Every region is checked on its way out. The checks are:
- no field is negative;
- the origin and the extent fit within the fixed mode limits;
- the region lies inside the surface size that is currently programmed.

A region that fails any of these checks leaves the block as a full-surface repaint, (0, 0, surface width, surface height). The block is never stalled by a bad region.

A separate invalidate pulse marks the whole display stale. At the next flush, every pending region is discarded and a single full-surface repaint is sent in their place. The block takes no part in pixel movement or memory traffic. It only orders and sanitises the repaint requests.

Top module: `dirty_rect_queue`

## Requirements
- R1: After reset the queue is empty, the invalidate flag is clear and `upd_valid` is low; a flush issued straight after reset emits nothing.
- R2: During a drain, regions leave in push order, one per cycle in which `upd_valid` and `upd_ready` are both high. While `upd_ready` is low, `upd_valid` stays high and the same region stays presented.
- R3: A push is accepted in every cycle, including a cycle with a handshake. A region pushed while a drain is running is emitted by that same drain.
- R4: Coordinates are two's complement, `CW` bits wide. A region with any negative field is emitted as (0, 0, `surf_w`, `surf_h`).
- R5: A region whose x or w exceeds `MAX_W` (default 2368), or whose y or h exceeds `MAX_H` (default 1770), is emitted as (0, 0, `surf_w`, `surf_h`). A value equal to the limit passes this check.
- R6: A region with x + w > `surf_w` or y + h > `surf_h` is emitted as a full-surface region. A sum equal to the surface size passes unchanged.
- R7: If the invalidate flag is set, a flush discards every pending region and emits exactly one (0, 0, `surf_w`, `surf_h`) region. The flag clears on that handshake, unless a new invalidate pulse arrives in the same cycle. A push made in the handshake cycle survives.
- R8: The read and write indices wrap modulo `DEPTH` and pushes are never refused. After exactly `DEPTH` pushes with no pops the queue reads as empty. After `DEPTH`+1 pushes it holds only the newest region.
- R9: `upd_valid` is high only while a drain is running. A drain starts on `flush` and ends once the queue is empty and no invalidation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Write one region into the queue this cycle |
| push_x | input | CW | Region origin x, signed |
| push_y | input | CW | Region origin y, signed |
| push_w | input | CW | Region width, signed |
| push_h | input | CW | Region height, signed |
| surf_w | input | CW | Current surface width, unsigned |
| surf_h | input | CW | Current surface height, unsigned |
| invalidate | input | 1 | Mark the whole display stale |
| flush | input | 1 | Start draining the queue |
| upd_valid | output | 1 | A region is presented on the update port |
| upd_ready | input | 1 | Display side accepts the presented region |
| upd_x | output | CW | Emitted origin x |
| upd_y | output | CW | Emitted origin y |
| upd_w | output | CW | Emitted width |
| upd_h | output | CW | Emitted height |

## Verification
The hardest case to reach from the ports is index wrap without overflow protection. It needs hundreds of back-to-back pushes with no flush in between. The write index then laps the read index, and the queue either looks empty or shows only the newest region. The stimulus pushes exactly `DEPTH` and then `DEPTH`+1 regions with no flush in between, and checks that the following flush emits nothing in the first case and only the last region in the second. A second hard case is an invalidate that lands while regions are still draining under a stalled `upd_ready`. Random ready throttling, mixed with invalidate pulses timed during drains, brings the queue into that state.

// File: rtl/dirty_rect_queue.sv
module dirty_rect_queue #(
  parameter int CW    = 16,
  parameter int DEPTH = 512,
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [CW-1:0] push_x,
  input  logic [CW-1:0] push_y,
  input  logic [CW-1:0] push_w,
  input  logic [CW-1:0] push_h,
  input  logic [CW-1:0] surf_w,
  input  logic [CW-1:0] surf_h,
  input  logic          invalidate,
  input  logic          flush,
  output logic          upd_valid,
  input  logic          upd_ready,
  output logic [CW-1:0] upd_x,
  output logic [CW-1:0] upd_y,
  output logic [CW-1:0] upd_w,
  output logic [CW-1:0] upd_h
);
  localparam int AW = $clog2(DEPTH);

  logic [CW-1:0] mem_x [DEPTH];
  logic [CW-1:0] mem_y [DEPTH];
  logic [CW-1:0] mem_w [DEPTH];
  logic [CW-1:0] mem_h [DEPTH];

  logic [AW-1:0] wr_q, rd_q;
  logic          inval_q, drain_q;

  logic [CW-1:0] hx, hy, hw, hh;
  logic          empty, hs, neg, over, spill, full;
  logic [CW:0]   sum_x, sum_y;

  assign hx    = mem_x[rd_q];
  assign hy    = mem_y[rd_q];
  assign hw    = mem_w[rd_q];
  assign hh    = mem_h[rd_q];
  assign empty = (rd_q == wr_q);

  assign neg   = hx[CW-1] | hy[CW-1] | hw[CW-1] | hh[CW-1];
  assign over  = ($signed(hx) > MAX_W) | ($signed(hw) > MAX_W) |
                 ($signed(hy) > MAX_H) | ($signed(hh) > MAX_H);
  assign sum_x = {1'b0, hx} + {1'b0, hw};
  assign sum_y = {1'b0, hy} + {1'b0, hh};
  assign spill = (sum_x > {1'b0, surf_w}) | (sum_y > {1'b0, surf_h});
  assign full  = inval_q | neg | over | spill;

  assign upd_valid = drain_q & (inval_q | !empty);
  assign hs        = upd_valid & upd_ready;
  assign upd_x     = full ? '0 : hx;
  assign upd_y     = full ? '0 : hy;
  assign upd_w     = full ? surf_w : hw;
  assign upd_h     = full ? surf_h : hh;

  always_ff @(posedge clk) begin
    if (push_valid) begin
      mem_x[wr_q] <= push_x;
      mem_y[wr_q] <= push_y;
      mem_w[wr_q] <= push_w;
      mem_h[wr_q] <= push_h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      inval_q <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      if (push_valid) wr_q <= wr_q + 1'b1;
      if (hs) rd_q <= inval_q ? wr_q : rd_q + 1'b1;
      if (invalidate)        inval_q <= 1'b1;
      else if (hs & inval_q) inval_q <= 1'b0;
      if (flush)                              drain_q <= 1'b1;
      else if (drain_q & !inval_q & empty)    drain_q <= 1'b0;
    end
  end

  // R2
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready && !push_valid |=> upd_valid);

  // R3
  push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> wr_q == $past(wr_q) + 1'b1);

  // R4
  neg_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && hx[CW-1] |-> upd_x == '0 && upd_y == '0 && upd_w == surf_w && upd_h == surf_h);

  // R6
  inside_surface_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ({1'b0, upd_x} + {1'b0, upd_w} <= {1'b0, surf_w}) &&
                  ({1'b0, upd_y} + {1'b0, upd_h} <= {1'b0, surf_h}));

  // R7
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && inval_q && !invalidate && !push_valid |=> !inval_q && rd_q == wr_q);

  // R9
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q && !inval_q && empty && !flush && !invalidate |=> !upd_valid);
endmodule

// File: tb/test_dirty_rect_queue.sv
module test_dirty_rect_queue;
  localparam int CW = 16, DEPTH = 512, MAX_W = 2368, MAX_H = 1770;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, invalidate = 0, flush = 0, upd_ready = 0, upd_valid;
  logic [CW-1:0] push_x = 0, push_y = 0, push_w = 0, push_h = 0;
  logic [CW-1:0] surf_w = 16'd1024, surf_h = 16'd768;
  logic [CW-1:0] upd_x, upd_y, upd_w, upd_h;

  always #2 clk = ~clk;

  dirty_rect_queue #(.CW(CW), .DEPTH(DEPTH), .MAX_W(MAX_W), .MAX_H(MAX_H)) i_dirty_rect_queue (
    .clk, .rst_n, .push_valid, .push_x, .push_y, .push_w, .push_h,
    .surf_w, .surf_h, .invalidate, .flush, .upd_valid, .upd_ready,
    .upd_x, .upd_y, .upd_w, .upd_h);

  int n_chk = 0, n_bad = 0, cyc = 0, emitted = 0;
  int mqx[DEPTH], mqy[DEPTH], mqw[DEPTH], mqh[DEPTH];
  int mwr = 0, mrd = 0;
  bit minval = 0, mdrain = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic string reason(int x, int y, int w, int h);
    if (minval) return "R7";
    if (x < 0 || y < 0 || w < 0 || h < 0) return "R4";
    if (x > MAX_W || w > MAX_W || y > MAX_H || h > MAX_H) return "R5";
    if (x + w > int'(surf_w) || y + h > int'(surf_h)) return "R6";
    return "R2";
  endfunction

  task automatic step(bit p, int x, int y, int w, int h, bit f, bit inv, bit rdy);
    bit ev, hs;
    int ex, ey, ew, eh;
    string rq;
    ev = mdrain && (minval || mrd != mwr);
    check(upd_valid == ev, "R9", upd_valid, ev);
    hs = ev && rdy;
    if (hs) begin
      rq = reason(mqx[mrd], mqy[mrd], mqw[mrd], mqh[mrd]);
      if (rq == "R2") begin ex = mqx[mrd]; ey = mqy[mrd]; ew = mqw[mrd]; eh = mqh[mrd]; end
      else begin ex = 0; ey = 0; ew = surf_w; eh = surf_h; end
      check(int'(upd_x) == ex, rq, upd_x, ex);
      check(int'(upd_y) == ey, rq, upd_y, ey);
      check(int'(upd_w) == ew, rq, upd_w, ew);
      check(int'(upd_h) == eh, rq, upd_h, eh);
      emitted++;
    end
    push_valid = p; push_x = x[CW-1:0]; push_y = y[CW-1:0];
    push_w = w[CW-1:0]; push_h = h[CW-1:0];
    flush = f; invalidate = inv; upd_ready = rdy;
    @(posedge clk);
    if (f) mdrain = 1;
    else if (mdrain && !minval && mrd == mwr) mdrain = 0;
    if (hs) begin
      if (minval) begin mrd = mwr; minval = 0; end
      else mrd = (mrd + 1) % DEPTH;
    end
    if (inv) minval = 1;
    if (p) begin
      mqx[mwr] = sx(x & 16'hffff); mqy[mwr] = sx(y & 16'hffff);
      mqw[mwr] = sx(w & 16'hffff); mqh[mwr] = sx(h & 16'hffff);
      mwr = (mwr + 1) % DEPTH;
    end
    @(negedge clk);
  endtask

  task automatic push(int x, int y, int w, int h);
    step(1, x, y, w, h, 0, 0, 0);
  endtask

  task automatic drain(int rdy_pct);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 4000 && mdrain; k++)
      step(0, 0, 0, 0, 0, 0, 0, ($urandom % 100) < rdy_pct);
    step(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  function automatic int rc(int lim);
    int r;
    r = $urandom % 10;
    if (r == 0) return -1 - int'($urandom % 40);
    if (r == 1) return lim + int'($urandom % 300) - 150;
    return $urandom % (lim / 2 + 1);
  endfunction

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, flush yields nothing
    check(upd_valid == 1'b0, "R1", upd_valid, 0);
    e0 = emitted; drain(100);
    check(emitted == e0, "R1", emitted - e0, 0);

    // R2: order, with stalls
    for (int i = 0; i < 6; i++) push(10 * i, 5 * i, 20, 30);
    e0 = emitted; drain(40);
    check(emitted - e0 == 6, "R2", emitted - e0, 6);

    // R4 R5 R6 boundaries
    surf_w = 16'd4000; surf_h = 16'd4000;
    push(-1, 0, 5, 5); push(0, 0, 5, -3);
    push(MAX_W, 0, 0, 1); push(MAX_W + 1, 0, 0, 1);
    push(0, MAX_H, 1, 0); push(0, 0, 1, MAX_H + 1);
    e0 = emitted; drain(100);
    check(emitted - e0 == 6, "R5", emitted - e0, 6);
    surf_w = 16'd800; surf_h = 16'd600;
    push(300, 100, 500, 500); push(300, 100, 501, 10);
    push(0, 0, 800, 601); push(799, 599, 1, 1);
    drain(70);

    // R7: invalidate discards queue
    for (int i = 0; i < 5; i++) push(i, i, 3, 3);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    e0 = emitted; drain(50);
    check(emitted - e0 == 1, "R7", emitted - e0, 1);
    push(1, 2, 3, 4); push(5, 6, 7, 8);
    e0 = emitted; drain(100);
    check(emitted - e0 == 2, "R7", emitted - e0, 2);

    // R8: wrap without overflow guard
    for (int i = 0; i < DEPTH; i++) push(i % 700, 1, 1, 1);
    e0 = emitted; drain(100);
    check(emitted == e0, "R8", emitted - e0, 0);
    for (int i = 0; i <= DEPTH; i++) push(i % 700, 2, 3, 4);
    e0 = emitted; drain(100);
    check(emitted - e0 == 1, "R8", emitted - e0, 1);

    // R3: pushes during a drain
    push(1, 1, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, i, i, 2, 2, 0, 0, $urandom % 2);
    e0 = emitted;
    for (int k = 0; k < 200 && mdrain; k++) step(0, 0, 0, 0, 0, 0, 0, 1);
    check(mrd == mwr && !upd_valid, "R3", upd_valid, 0);

    // random mix
    for (int r = 0; r < 40; r++) begin
      surf_w = 16'(200 + $urandom % 2300); surf_h = 16'(100 + $urandom % 1700);
      for (int c = 0; c < 60; c++)
        step(($urandom % 3) == 0, rc(surf_w), rc(surf_h), rc(surf_w), rc(surf_h),
             ($urandom % 25) == 0, ($urandom % 60) == 0, ($urandom % 4) != 0);
      for (int k = 0; k < 2000 && (mdrain || mrd != mwr || minval); k++)
        step(0, 0, 0, 0, 0, !mdrain, 0, ($urandom % 3) != 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule